// File: doc/BRIEF.md
# Rice coding option selector

This block sits between the prediction-error mapper and the bitstream packer of a Rice-style lossless coder. It takes mapped 8-bit samples, one per cycle when `valid_i` is high, and groups them into coding blocks of 8, 16, 32 or 64 samples. While the block streams in, it keeps running totals for every coding choice at once. The choices are split-sample with k from 0 to 6, the paired second-extension code, and raw transmission. It also tracks whether every sample so far is zero.

One cycle after the last sample of a block is accepted, the block issues a one-cycle `done_o` pulse. With it come the cheapest option, its split parameter and its payload bit count, meaning the coded data bits without the option identifier. An all-zero block is reported through its own flag and option code. Counting runs of zero blocks and emitting the bitstream are left to downstream logic.

Top module: `rice_opt_sel`

## Requirements
- R1: The block length J comes from `blk_sel_i` (0→8, 1→16, 2→32, 3→64 samples). It is sampled when the first sample of a block is accepted and held for the rest of that block.
- R2: Split option k (1..6) costs J·k plus the sum over samples of ((v >> k) + 1) bits.
- R3: Split option k=0 is the fundamental-sequence code and costs the sum of (v + 1) over the block.
- R4: The second-extension option pairs samples in order (a, b). Each pair costs γ + 1 bits, with γ = (a+b)(a+b+1)/2 + b. The running total saturates at 65535.
- R5: The raw option costs J·8 bits.
- R6: The reported option is the one with the fewest bits, and `bits_o` carries that count. `opt_o` encodes 0 = zero block, 1 = second extension, 2 = split-sample, 3 = raw.
- R7: Ties go in this order: the lowest split k first, then second extension, then raw. `k_o` is 0 whenever `opt_o` is not 2.
- R8: A block whose samples are all zero reports `opt_o`=0, `k_o`=0, `bits_o`=0 and `zero_o`=1. Any other block reports `zero_o`=0.
- R9: `done_o` is high for exactly one cycle, in the cycle after the clock edge that accepts the last sample. Results hold until the next pulse. Cycles with `valid_i` low are ignored. A new block may start on the cycle right after the last sample.
- R10: While `rst_ni` is low, all outputs are 0 and any partial block is discarded. The next accepted sample starts a new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample present this cycle |
| blk_sel_i | input | 2 | Block length select, taken at the first sample |
| sample_i | input | 8 | Mapped sample value |
| done_o | output | 1 | Result pulse |
| opt_o | output | 2 | Chosen option code |
| k_o | output | 3 | Split parameter of the chosen option |
| bits_o | output | 16 | Payload bit count of the chosen option |
| zero_o | output | 1 | Block was all zeros |

## Verification
The bench aims at the cost ties: all-ones blocks, where k=0 and k=1 cost the same; alternating 0/1 pairs, where fundamental sequence and second extension cost the same; and constant-64 blocks, where k=5, k=6 and raw cost the same. A wrong tie-break shows up there as the wrong option or k. A block of all 255 at J=64 drives the second-extension total far past 16 bits. An accumulator that wraps instead of saturating could then pick the wrong winner or give a wrong bit count. Gapped streams, back-to-back blocks and a reset in mid-block catch counters that count idle cycles, clear late, or keep a stale partial block. In each of those cases the reported cycle or values would be wrong.

// File: rtl/rice_sel_pkg.sv
package rice_sel_pkg;
  localparam int unsigned CNT_W = 6;
  localparam int unsigned LEN_W = CNT_W + 1;

  typedef enum logic [1:0] {
    OPT_ZERO   = 2'd0,
    OPT_SECEXT = 2'd1,
    OPT_SPLIT  = 2'd2,
    OPT_RAW    = 2'd3
  } opt_e;

  function automatic logic [LEN_W-1:0] blk_len(input logic [1:0] sel);
    return LEN_W'(8) << sel;
  endfunction
endpackage

// File: rtl/rice_sample_ctr.sv
module rice_sample_ctr
  import rice_sel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       blk_sel_i,
  output logic             last_o,
  output logic             odd_o,
  output logic [LEN_W-1:0] len_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q, len_eff;

  // length is taken from the port only on the first sample
  assign len_eff = (cnt_q == '0) ? blk_len(blk_sel_i) : len_q;
  assign last_o  = valid_i && ({1'b0, cnt_q} == len_eff - LEN_W'(1));
  assign odd_o   = cnt_q[0];
  assign len_o   = len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      len_q <= LEN_W'(8);
    end else if (valid_i) begin
      len_q <= len_eff;
      cnt_q <= last_o ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rice_split_acc.sv
module rice_split_acc #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned MAX_K    = 6,
  parameter int unsigned COST_W   = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           valid_i,
  input  logic                           clear_i,
  input  logic [SAMPLE_W-1:0]            sample_i,
  output logic [MAX_K:0][COST_W-1:0]     sum_o
);
  for (genvar gk = 0; gk <= MAX_K; gk++) begin : g_k
    logic [COST_W-1:0] acc_q, base, term;
    assign base = clear_i ? '0 : acc_q;
    assign term = valid_i ? COST_W'(sample_i >> gk) + COST_W'(1) : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) acc_q <= '0;
      else         acc_q <= base + term;
    end
    assign sum_o[gk] = acc_q;
  end
endmodule

// File: rtl/rice_secext_acc.sv
module rice_secext_acc #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned COST_W   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                clear_i,
  input  logic                odd_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [COST_W-1:0]   cost_o
);
  localparam int unsigned GW   = 2 * (SAMPLE_W + 1);
  localparam int unsigned SW   = ((GW > COST_W) ? GW : COST_W) + 1;
  localparam logic [SW-1:0] CMAX = SW'({COST_W{1'b1}});

  logic [SAMPLE_W-1:0] a_q;
  logic [SAMPLE_W:0]   pair_sum;
  logic [GW-1:0]       prod, term;
  logic [COST_W-1:0]   acc_q, base;
  logic [SW-1:0]       wide;

  assign pair_sum = {1'b0, a_q} + {1'b0, sample_i};
  assign prod     = GW'(pair_sum) * GW'(pair_sum + (SAMPLE_W+1)'(1));
  assign term     = (prod >> 1) + GW'(sample_i) + GW'(1);
  assign base     = clear_i ? '0 : acc_q;
  assign wide     = SW'(base) + ((valid_i && odd_i) ? SW'(term) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      acc_q <= '0;
    end else begin
      if (valid_i && !odd_i) a_q <= sample_i;
      acc_q <= (wide > CMAX) ? CMAX[COST_W-1:0] : wide[COST_W-1:0];
    end
  end

  assign cost_o = acc_q;
endmodule

// File: rtl/rice_opt_pick.sv
module rice_opt_pick
  import rice_sel_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned MAX_K    = 6,
  parameter int unsigned COST_W   = 16,
  parameter int unsigned KW       = 3
) (
  input  logic [MAX_K:0][COST_W-1:0] split_sum_i,
  input  logic [COST_W-1:0]          se_cost_i,
  input  logic [LEN_W-1:0]           len_i,
  input  logic                       all_zero_i,
  output opt_e                       opt_o,
  output logic [KW-1:0]              k_o,
  output logic [COST_W-1:0]          bits_o
);
  logic [MAX_K:0][COST_W-1:0] tot;
  logic [COST_W-1:0]          raw;

  for (genvar gk = 0; gk <= MAX_K; gk++) begin : g_tot
    assign tot[gk] = split_sum_i[gk] + COST_W'(len_i) * COST_W'(gk);
  end
  assign raw = COST_W'(len_i) * COST_W'(SAMPLE_W);

  // strict compares keep the earlier candidate on a tie
  always_comb begin
    opt_o  = OPT_SPLIT;
    k_o    = '0;
    bits_o = tot[0];
    for (int k = 1; k <= int'(MAX_K); k++) begin
      if (tot[k] < bits_o) begin
        bits_o = tot[k];
        k_o    = KW'(k);
      end
    end
    if (se_cost_i < bits_o) begin
      opt_o  = OPT_SECEXT;
      k_o    = '0;
      bits_o = se_cost_i;
    end
    if (raw < bits_o) begin
      opt_o  = OPT_RAW;
      k_o    = '0;
      bits_o = raw;
    end
    if (all_zero_i) begin
      opt_o  = OPT_ZERO;
      k_o    = '0;
      bits_o = '0;
    end
  end
endmodule

// File: rtl/rice_opt_sel.sv
module rice_opt_sel
  import rice_sel_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned MAX_K    = 6,
  parameter int unsigned COST_W   = 16,
  parameter int unsigned KW       = $clog2(MAX_K + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [1:0]          blk_sel_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                done_o,
  output logic [1:0]          opt_o,
  output logic [KW-1:0]       k_o,
  output logic [COST_W-1:0]   bits_o,
  output logic                zero_o
);
  logic                       last, odd, blk_end_q, zero_acc_q, zero_base;
  logic [LEN_W-1:0]           len;
  logic [MAX_K:0][COST_W-1:0] split_sum;
  logic [COST_W-1:0]          se_cost, pick_bits;
  logic [KW-1:0]              pick_k;
  opt_e                       pick_opt;

  rice_sample_ctr u_ctr (
    .clk_i, .rst_ni, .valid_i, .blk_sel_i,
    .last_o (last),
    .odd_o  (odd),
    .len_o  (len)
  );

  rice_split_acc #(.SAMPLE_W(SAMPLE_W), .MAX_K(MAX_K), .COST_W(COST_W)) u_split (
    .clk_i, .rst_ni, .valid_i,
    .clear_i  (blk_end_q),
    .sample_i,
    .sum_o    (split_sum)
  );

  rice_secext_acc #(.SAMPLE_W(SAMPLE_W), .COST_W(COST_W)) u_secext (
    .clk_i, .rst_ni, .valid_i,
    .clear_i  (blk_end_q),
    .odd_i    (odd),
    .sample_i,
    .cost_o   (se_cost)
  );

  rice_opt_pick #(.SAMPLE_W(SAMPLE_W), .MAX_K(MAX_K), .COST_W(COST_W), .KW(KW)) u_pick (
    .split_sum_i (split_sum),
    .se_cost_i   (se_cost),
    .len_i       (len),
    .all_zero_i  (zero_acc_q),
    .opt_o       (pick_opt),
    .k_o         (pick_k),
    .bits_o      (pick_bits)
  );

  assign zero_base = blk_end_q ? 1'b1 : zero_acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_end_q  <= 1'b0;
      zero_acc_q <= 1'b1;
      done_o     <= 1'b0;
      opt_o      <= '0;
      k_o        <= '0;
      bits_o     <= '0;
      zero_o     <= 1'b0;
    end else begin
      blk_end_q  <= last;
      zero_acc_q <= zero_base & (!valid_i || (sample_i == '0));
      done_o     <= blk_end_q;
      if (blk_end_q) begin
        opt_o  <= pick_opt;
        k_o    <= pick_k;
        bits_o <= pick_bits;
        zero_o <= zero_acc_q;
      end
    end
  end
endmodule

// File: rtl/rice_opt_sel_chk.sv
module rice_opt_sel_chk #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned COST_W   = 16,
  parameter int unsigned KW       = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_i,
  input logic [1:0]        opt_i,
  input logic [KW-1:0]     k_i,
  input logic [COST_W-1:0] bits_i,
  input logic              zero_i,
  input logic [COST_W-1:0] se_cost_i,
  input logic              restart_i
);
  // R9
  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);
  // R9
  a_r9_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable({opt_i, k_i, bits_i, zero_i}) || done_i);
  // R8
  a_r8_zero_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && zero_i) |-> (opt_i == 2'd0 && k_i == '0 && bits_i == '0));
  // R8
  a_r8_zero_code_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && opt_i == 2'd0) |-> zero_i);
  // R5
  a_r5_raw_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (bits_i <= COST_W'(64 * SAMPLE_W)));
  // R7
  a_r7_k_only_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && opt_i != 2'd2) |-> (k_i == '0));
  // R4
  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |=> (se_cost_i >= $past(se_cost_i)));
endmodule

bind rice_opt_sel rice_opt_sel_chk #(.SAMPLE_W(SAMPLE_W), .COST_W(COST_W), .KW(KW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .done_i    (done_o),
  .opt_i     (opt_o),
  .k_i       (k_o),
  .bits_i    (bits_o),
  .zero_i    (zero_o),
  .se_cost_i (se_cost),
  .restart_i (blk_end_q)
);

// File: tb/rice_opt_sel_bench.sv
module rice_opt_sel_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  blk_sel_i = '0;
  logic [7:0]  sample_i = '0;
  logic        done_o;
  logic [1:0]  opt_o;
  logic [2:0]  k_o;
  logic [15:0] bits_o;
  logic        zero_o;

  rice_opt_sel u_rice_opt_sel (.*);

  always #2 clk_i = ~clk_i;

  int total = 0, bad = 0, cyc = 0, last_cyc = 0, res_n = 0;
  int r_opt [64], r_k [64], r_bits [64], r_zero [64], r_cyc [64];
  logic [7:0] blk [64];

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i)
    if (done_o && res_n < 64) begin
      r_opt[res_n]  = int'(opt_o);
      r_k[res_n]    = int'(k_o);
      r_bits[res_n] = int'(bits_o);
      r_zero[res_n] = int'(zero_o);
      r_cyc[res_n]  = cyc;
      res_n++;
    end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // stimulus: [12:11] select, [10:8] pattern, [7:0] seed
  localparam logic [12:0] VEC [12] = '{
    {2'd0, 3'd3, 8'h5A}, {2'd1, 3'd1, 8'h33}, {2'd2, 3'd4, 8'h03},
    {2'd3, 3'd3, 8'hC1}, {2'd3, 3'd2, 8'hFF}, {2'd0, 3'd2, 8'h07},
    {2'd1, 3'd5, 8'h0F}, {2'd2, 3'd5, 8'h3F}, {2'd3, 3'd1, 8'h77},
    {2'd2, 3'd0, 8'h00}, {2'd1, 3'd2, 8'h20}, {2'd3, 3'd5, 8'h03}
  };

  function automatic void model(input int len, output int eo, output int ek,
                                output int eb, output int ez);
    int best, c, se, s;
    ez = 1;
    for (int i = 0; i < len; i++) if (blk[i] != 0) ez = 0;
    best = 1 << 30; eo = 2; ek = 0;
    for (int k = 0; k <= 6; k++) begin
      c = len * k;
      for (int i = 0; i < len; i++) c += (int'(blk[i]) >> k) + 1;
      if (c < best) begin best = c; ek = k; end
    end
    se = 0;
    for (int i = 0; i < len; i += 2) begin
      s = int'(blk[i]) + int'(blk[i+1]);
      se += s * (s + 1) / 2 + int'(blk[i+1]) + 1;
      if (se > 65535) se = 65535;
    end
    if (se < best) begin best = se; eo = 1; ek = 0; end
    if (len * 8 < best) begin best = len * 8; eo = 3; ek = 0; end
    if (ez == 1) begin eo = 0; ek = 0; best = 0; end
    eb = best;
  endfunction

  task automatic send(input logic [1:0] sel, input bit gap);
    int len = 8 << sel;
    for (int i = 0; i < len; i++) begin
      @(negedge clk_i);
      if (gap && i[0]) begin
        valid_i = 1'b0; sample_i = 8'hFF; blk_sel_i = ~sel;
        @(negedge clk_i);
      end
      valid_i = 1'b1; sample_i = blk[i]; blk_sel_i = (i == 0) ? sel : ~sel;
      last_cyc = cyc;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0; sample_i = '0;
    end
  endtask

  task automatic expect_res(input int idx, input string tag, input int eo,
                            input int ek, input int eb, input int ez, input int ecyc);
    if (res_n <= idx) begin
      check({tag, " R9 done missing"}, res_n, idx + 1);
      return;
    end
    check({tag, " R9/R1 done cycle"}, r_cyc[idx], ecyc);
    check({tag, " R6 option"}, r_opt[idx], eo);
    check({tag, " R7 k"}, r_k[idx], ek);
    check({tag, " R2 bits"}, r_bits[idx], eb);
    check({tag, " R8 zero flag"}, r_zero[idx], ez);
  endtask

  task automatic fill(input int len, input int v);
    for (int i = 0; i < len; i++) blk[i] = 8'(v);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int eo, ek, eb, ez, len, n0;
    logic [7:0] x;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check("R10 reset done_o", int'(done_o), 0);
    check("R10 reset bits_o", int'(bits_o), 0);
    check("R10 reset opt_o", int'(opt_o), 0);
    rst_ni = 1'b1;
    idle(2);

    foreach (VEC[v]) begin
      len = 8 << VEC[v][12:11];
      x = VEC[v][7:0] | 8'h01;
      for (int i = 0; i < len; i++) begin
        x = {x[6:0], x[7] ^ x[5] ^ x[4] ^ x[3]};
        case (VEC[v][10:8])
          3'd0: blk[i] = '0;
          3'd1: blk[i] = {7'd0, x[0]};
          3'd2: blk[i] = VEC[v][7:0];
          3'd4: blk[i] = 8'(i * int'(VEC[v][7:0]));
          3'd5: blk[i] = x & VEC[v][7:0];
          default: blk[i] = x;
        endcase
      end
      model(len, eo, ek, eb, ez);
      n0 = res_n;
      send(VEC[v][12:11], v[0]);   // odd entries: R9 idle gaps ignored
      idle(4);
      expect_res(n0, $sformatf("vec%0d", v), eo, ek, eb, ez, last_cyc + 2);
    end

    // R3 R7: all ones, k0 and k1 tie at 16
    fill(8, 1); n0 = res_n; send(2'd0, 1'b0); idle(4);
    expect_res(n0, "R3 ones", 2, 0, 16, 0, last_cyc + 2);

    // R7: pairs (0,1), fundamental sequence ties second extension at 12
    for (int i = 0; i < 8; i++) blk[i] = 8'(i % 2);
    n0 = res_n; send(2'd0, 1'b0); idle(4);
    expect_res(n0, "R7 fs_vs_se", 2, 0, 12, 0, last_cyc + 2);

    // R4: pairs (1,0), second extension wins at 8
    for (int i = 0; i < 8; i++) blk[i] = 8'((i + 1) % 2);
    n0 = res_n; send(2'd0, 1'b0); idle(4);
    expect_res(n0, "R4 se_win", 1, 0, 8, 0, last_cyc + 2);

    // R7: constant 64, k5, k6 and raw all 64
    fill(8, 64); n0 = res_n; send(2'd0, 1'b0); idle(4);
    expect_res(n0, "R7 raw_tie", 2, 5, 64, 0, last_cyc + 2);

    // R4 R5: constant 255 at J=64, second extension saturates, raw wins
    fill(64, 255); n0 = res_n; send(2'd3, 1'b0); idle(4);
    expect_res(n0, "R5 raw_sat", 3, 0, 512, 0, last_cyc + 2);
    check("R9 result held", int'(bits_o), 512);

    // R9 R8: back-to-back blocks
    fill(8, 1); n0 = res_n; send(2'd0, 1'b0);
    eb = last_cyc;
    fill(16, 0); send(2'd1, 1'b0); idle(4);
    expect_res(n0, "R9 b2b_first", 2, 0, 16, 0, eb + 2);
    expect_res(n0 + 1, "R8 b2b_zero", 0, 0, 0, 1, last_cyc + 2);

    // R10: reset in mid-block discards the partial block
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i); valid_i = 1'b1; sample_i = 8'd200; blk_sel_i = 2'd0;
    end
    @(negedge clk_i); valid_i = 1'b0; rst_ni = 1'b0;
    @(negedge clk_i);
    check("R10 mid reset bits_o", int'(bits_o), 0);
    check("R10 mid reset zero_o", int'(zero_o), 0);
    rst_ni = 1'b1;
    idle(2);
    fill(8, 1); n0 = res_n; send(2'd0, 1'b0); idle(4);
    expect_res(n0, "R10 restart", 2, 0, 16, 0, last_cyc + 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule